// File: doc/BRIEF.md
# Sticky Fault Register with Edge-Armed Bus Alert

This block keeps six fault conditions of a power-path controller in a sticky fault register. It drives an open-drain alert line toward the host bus. The six conditions are input overvoltage, input undervoltage, overcurrent, power bad, enable-pin change and switch short. Each condition arrives as a level that is already synchronized, and its rising edge latches the matching fault bit. A per-fault enable register chooses which latched faults may raise the alert.

Once the alert has been raised, the bus interface can release it in two ways. It pulses `ara_done_i` when the device has sent its own address in reply to an alert-response query. It pulses `addressed_i` when the device is addressed for any transaction. After a release, a fault that stays set, or whose condition comes back, raises no new alert. The line is pulled again only in two cases: a different enabled fault bit latches, or the host clears a fault bit and that bit latches again later.

The top two bits of the fault register are plain output bits. Bit 6 pulls the alert line low as well. Bit 7 drives a second open-drain line.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset the fault register reads 0x80 (bits 5:0 and 6 clear, bit 7 set), the enable register reads 0, `alert_active_o` and `alert_pull_low_o` are 0, and `aux_pull_low_o` is 1.
- R2: A 0-to-1 change of `cond_i[k]` sets fault bit k (0 overvoltage, 1 undervoltage, 2 overcurrent, 3 power bad, 4 enable change, 5 switch short). A condition that stays high sets nothing further. A level that is already high when the host clears its bit leaves the bit clear.
- R3: Fault bits 5:0 stay set until a host write (`fault_wr_i`) carries 0 at that position. Writing 1 leaves the bit as it is. Without a write and without a rising condition, bits 5:0 do not change.
- R4: If a rising condition and a host write of 0 to the same bit fall in the same cycle, the bit ends up set.
- R5: `mask_wr_i` loads `mask_wdata_i[5:0]` into the enable register. `alert_active_o` is 1 exactly when some fault bit k is set, enable bit k is 1, and bit k has not been released since it last became set. A fault whose enable bit is 0 raises no alert. Enabling a set, unreleased fault later raises the alert.
- R6: A pulse on `ara_done_i` or on `addressed_i` marks every currently set fault bit as released. `alert_active_o` falls at the next clock edge unless a new enabled fault or a new enable arrives in that same cycle.
- R7: A released fault bit raises no new alert while it stays set, even if its condition falls and rises again. The alert is raised again when a different enabled fault bit latches, or when the released bit is cleared by the host and latches again.
- R8: A fault bit that latches in the same cycle as a release pulse is not marked released, so the alert stays raised for it.
- R9: A host write loads bits 6 and 7 of the fault register directly from `fault_wdata_i`. `aux_pull_low_o` follows bit 7.
- R10: `alert_pull_low_o` is 1 when `alert_active_o` is 1 or fault bit 6 is 1. All outputs reflect an input change after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 6 | Synchronized fault condition levels, 1 = condition present |
| fault_wr_i | input | 1 | Host write strobe for the fault register |
| fault_wdata_i | input | 8 | Host write data for the fault register |
| mask_wr_i | input | 1 | Host write strobe for the alert enable register |
| mask_wdata_i | input | 6 | Host write data for the alert enable register |
| ara_done_i | input | 1 | Pulse: own address sent in reply to an alert-response query |
| addressed_i | input | 1 | Pulse: device addressed for a transaction |
| fault_q_o | output | 8 | Fault register contents |
| mask_q_o | output | 6 | Alert enable register contents |
| alert_active_o | output | 1 | An enabled, unreleased fault is pending |
| alert_pull_low_o | output | 1 | Pull the alert line low |
| aux_pull_low_o | output | 1 | Pull the second open-drain line low |

## Verification
The embedded properties check several rules on every cycle. Fault bits never drop without a host write, and a rising condition always wins over a clear. A release with no new event always drops the alert. The alert never rises without a new latch or a new enable, and bit 7 follows what the host wrote. Other behaviours are shown only by the bench's ordered scenarios. These are: re-arming a bit after a clear, raising the alert for a different fault while an older one is released, a release that coincides with a new latch, and the clear-while-condition-persists case.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  localparam int unsigned FLT_COUNT = 6;
  localparam int unsigned GPO_OFS   = 0;
  localparam int unsigned AUX_OFS   = 1;
endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  function automatic logic [W-1:0] rising(input logic [W-1:0] cur, input logic [W-1:0] prev);
    return cur & ~prev;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign rise_o = rising(level_i, prev_q);
endmodule

// File: rtl/fault_latch.sv
module fault_latch
  import fault_alert_pkg::*;
#(
  parameter int unsigned NFLT = FLT_COUNT,
  localparam int unsigned RW  = NFLT + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] set_evt_i,
  input  logic            wr_i,
  input  logic [RW-1:0]   wdata_i,
  output logic [NFLT-1:0] sticky_q_o,
  output logic [NFLT-1:0] sticky_d_o,
  output logic            gpo_q_o,
  output logic            aux_q_o
);
  logic [NFLT-1:0] sticky_q, sticky_d;
  logic            gpo_q, aux_q;

  function automatic logic [NFLT-1:0] next_sticky(
    input logic [NFLT-1:0] cur, input logic [NFLT-1:0] set,
    input logic wr, input logic [NFLT-1:0] wd);
    return set | (wr ? (cur & wd) : cur);
  endfunction

  assign sticky_d = next_sticky(sticky_q, set_evt_i, wr_i, wdata_i[NFLT-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      gpo_q    <= 1'b0;
      aux_q    <= 1'b1;
    end else begin
      sticky_q <= sticky_d;
      if (wr_i) begin
        gpo_q <= wdata_i[NFLT+GPO_OFS];
        aux_q <= wdata_i[NFLT+AUX_OFS];
      end
    end
  end

  assign sticky_q_o = sticky_q;
  assign sticky_d_o = sticky_d;
  assign gpo_q_o    = gpo_q;
  assign aux_q_o    = aux_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R3
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && set_evt_i == '0) |=> $stable(sticky_q)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt_i) |=> ((sticky_q & $past(set_evt_i)) == $past(set_evt_i))); // R4
endmodule

// File: rtl/alert_arm.sv
module alert_arm
  import fault_alert_pkg::*;
#(
  parameter int unsigned NFLT = FLT_COUNT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] fault_q_i,
  input  logic [NFLT-1:0] fault_d_i,
  input  logic [NFLT-1:0] mask_q_i,
  input  logic            release_i,
  input  logic            new_evt_i,
  input  logic            mask_wr_i,
  output logic            alert_active_o
);
  logic [NFLT-1:0] done_q, done_d, pend;

  function automatic logic [NFLT-1:0] pending(
    input logic [NFLT-1:0] f, input logic [NFLT-1:0] m, input logic [NFLT-1:0] d);
    return f & m & ~d;
  endfunction

  function automatic logic [NFLT-1:0] next_done(
    input logic [NFLT-1:0] f_now, input logic [NFLT-1:0] f_next,
    input logic [NFLT-1:0] d, input logic rel);
    return f_next & (d | (rel ? f_now : '0));
  endfunction

  assign done_d = next_done(fault_q_i, fault_d_i, done_q, release_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= done_d;
  end

  assign pend           = pending(fault_q_i, mask_q_i, done_q);
  assign alert_active_o = |pend;

  AST_ALERT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    alert_active_o |-> |(fault_q_i & mask_q_i)); // R5
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !new_evt_i && !mask_wr_i) |=> !alert_active_o); // R6
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!new_evt_i && !mask_wr_i && !alert_active_o) |=> !alert_active_o); // R7
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fault_alert_pkg::*;
#(
  parameter int unsigned NFLT = FLT_COUNT,
  localparam int unsigned RW  = NFLT + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] cond_i,
  input  logic            fault_wr_i,
  input  logic [RW-1:0]   fault_wdata_i,
  input  logic            mask_wr_i,
  input  logic [NFLT-1:0] mask_wdata_i,
  input  logic            ara_done_i,
  input  logic            addressed_i,
  output logic [RW-1:0]   fault_q_o,
  output logic [NFLT-1:0] mask_q_o,
  output logic            alert_active_o,
  output logic            alert_pull_low_o,
  output logic            aux_pull_low_o
);
  logic [NFLT-1:0] set_evt, sticky_q, sticky_d, mask_q;
  logic            gpo_q, aux_q, release_evt, new_evt, alert_active;

  assign release_evt = ara_done_i | addressed_i;
  assign new_evt     = |set_evt;

  rise_detect #(.W(NFLT)) u_rise (
    .clk(clk), .rst_n(rst_n), .level_i(cond_i), .rise_o(set_evt)
  );

  fault_latch #(.NFLT(NFLT)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_evt_i(set_evt),
    .wr_i(fault_wr_i), .wdata_i(fault_wdata_i),
    .sticky_q_o(sticky_q), .sticky_d_o(sticky_d),
    .gpo_q_o(gpo_q), .aux_q_o(aux_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  alert_arm #(.NFLT(NFLT)) u_arm (
    .clk(clk), .rst_n(rst_n), .fault_q_i(sticky_q), .fault_d_i(sticky_d),
    .mask_q_i(mask_q), .release_i(release_evt), .new_evt_i(new_evt),
    .mask_wr_i(mask_wr_i), .alert_active_o(alert_active)
  );

  assign fault_q_o        = {aux_q, gpo_q, sticky_q};
  assign mask_q_o         = mask_q;
  assign alert_active_o   = alert_active;
  assign alert_pull_low_o = alert_active | gpo_q;
  assign aux_pull_low_o   = aux_q;

  AST_AUX_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_wr_i |=> (aux_pull_low_o == $past(fault_wdata_i[RW-1]))); // R9
  AST_GPO_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_wr_i && fault_wdata_i[NFLT]) |=> alert_pull_low_o); // R10
endmodule

// File: tb/fault_alert_ctrl_tb.sv
`timescale 1ns/1ps
module fault_alert_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cond = '0;
  logic       fwr = 1'b0;
  logic [7:0] fwd = '0;
  logic       mwr = 1'b0;
  logic [5:0] mwd = '0;
  logic       ara = 1'b0;
  logic       adr = 1'b0;
  logic [7:0] fault_q;
  logic [5:0] mask_q;
  logic       act, pin, aux;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fault_alert_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .fault_wr_i(fwr),
    .fault_wdata_i(fwd), .mask_wr_i(mwr), .mask_wdata_i(mwd),
    .ara_done_i(ara), .addressed_i(adr), .fault_q_o(fault_q),
    .mask_q_o(mask_q), .alert_active_o(act), .alert_pull_low_o(pin),
    .aux_pull_low_o(aux)
  );

  // {cond, fwr, fwd, mwr, mwd, ara, adr, exp_fault, exp_act, exp_pin, exp_aux, req}
  localparam int NV = 18;
  localparam logic [38:0] TBL [0:NV-1] = '{
    {6'b000000,1'b0,8'h00,1'b1,6'b000111,1'b0,1'b0,8'h80,1'b0,1'b0,1'b1,4'd5},  // R5 enable 0..2
    {6'b000001,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h81,1'b1,1'b1,1'b1,4'd2},  // R2 overvoltage rises
    {6'b000001,1'b0,8'h00,1'b0,6'b000000,1'b1,1'b0,8'h81,1'b0,1'b0,1'b1,4'd6},  // R6 query answered
    {6'b000000,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h81,1'b0,1'b0,1'b1,4'd3},  // R3 sticky after fall
    {6'b000001,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h81,1'b0,1'b0,1'b1,4'd7},  // R7 repeat, no alert
    {6'b000000,1'b1,8'h80,1'b0,6'b000000,1'b0,1'b0,8'h80,1'b0,1'b0,1'b1,4'd3},  // R3 host clears bit0
    {6'b000001,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h81,1'b1,1'b1,1'b1,4'd7},  // R7 re-armed bit0
    {6'b000001,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b1,8'h81,1'b0,1'b0,1'b1,4'd6},  // R6 addressed
    {6'b000011,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h83,1'b1,1'b1,1'b1,4'd7},  // R7 different fault
    {6'b000111,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b1,8'h87,1'b1,1'b1,1'b1,4'd8},  // R8 release + new
    {6'b000111,1'b0,8'h00,1'b0,6'b000000,1'b1,1'b0,8'h87,1'b0,1'b0,1'b1,4'd6},  // R6 release all
    {6'b001111,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h8F,1'b0,1'b0,1'b1,4'd5},  // R5 masked fault
    {6'b001111,1'b1,8'hC0,1'b0,6'b000000,1'b0,1'b0,8'hC0,1'b0,1'b1,1'b1,4'd10}, // R10 gpo pulls pin
    {6'b000000,1'b1,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'd9},  // R9 aux released
    {6'b010000,1'b1,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h10,1'b0,1'b0,1'b0,4'd4},  // R4 set beats clear
    {6'b010000,1'b0,8'h00,1'b1,6'b010000,1'b0,1'b0,8'h10,1'b1,1'b1,1'b0,4'd5},  // R5 late enable
    {6'b110000,1'b0,8'h00,1'b0,6'b000000,1'b0,1'b0,8'h30,1'b1,1'b1,1'b0,4'd2},  // R2 switch short
    {6'b110000,1'b1,8'hFF,1'b0,6'b000000,1'b0,1'b0,8'hF0,1'b1,1'b1,1'b1,4'd3}   // R3 write 1 keeps
  };

  task automatic chk(input int req, input logic [7:0] actual, input logic [7:0] expected,
                     input string what);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  task automatic chk_reset_state();
    chk(1, fault_q, 8'h80, "fault after reset");   // R1
    chk(1, {2'b00, mask_q}, 8'h00, "mask after reset");
    chk(1, {7'd0, act}, 8'h00, "active after reset");
    chk(1, {7'd0, pin}, 8'h00, "pin after reset");
    chk(1, {7'd0, aux}, 8'h01, "aux after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state();
    for (int i = 0; i < NV; i++) begin
      cond = TBL[i][38:33]; fwr = TBL[i][32]; fwd = TBL[i][31:24];
      mwr  = TBL[i][23];    mwd = TBL[i][22:17];
      ara  = TBL[i][16];    adr = TBL[i][15];
      @(negedge clk);
      chk(int'(TBL[i][3:0]), fault_q, TBL[i][14:7], $sformatf("row %0d fault", i));
      chk(int'(TBL[i][3:0]), {7'd0, act}, {7'd0, TBL[i][6]}, $sformatf("row %0d active", i));
      chk(10, {7'd0, pin}, {7'd0, TBL[i][5]}, $sformatf("row %0d pin", i)); // R10
      chk(9, {7'd0, aux}, {7'd0, TBL[i][4]}, $sformatf("row %0d aux", i));  // R9
    end
    fwr = 1'b0; mwr = 1'b0; ara = 1'b0; adr = 1'b0;
    // R2: condition held across a clear leaves the bit clear
    fwd = 8'h80; fwr = 1'b1;
    @(negedge clk);
    fwr = 1'b0;
    @(negedge clk);
    chk(2, fault_q, 8'h80, "held level after clear");
    chk(7, {7'd0, act}, 8'h00, "no alert after clear");  // R7
    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk_reset_state();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule